// File: doc/BRIEF.md
# Serial Flash Write-Protection Unit

This block sits beside the command decoder of a 16 MB serial flash and rules on every program or erase request: is the addressed location write-protected or not. It supports two protection schemes. In the group scheme a 4-bit protect code and a top/bottom direction bit protect a power-of-two run of 64KB blocks, starting from one end of the array. In the individual scheme every protectable region carries a volatile lock bit and a nonvolatile lock bit. A write is allowed only when both bits are clear. A one-way mode command moves the block from the group scheme to the individual scheme.

The region map mixes two granularities. The sixteen 4KB sectors at each end of the array are lockable one by one. Each 64KB block in between is lockable as a whole. That gives 286 regions. The nonvolatile lock bits are modelled as registers that keep their value through a reset. A freeze command blocks any change to them until the next reset.

All commands arrive as already-decoded single-cycle strobes, with one shared 24-bit address. The protection verdict and lock-bit read-back come out as registered results one cycle after their strobe.

Top module: `flash_wp_unit`

## Requirements
- R1: In group mode the block index is address bits 23..16. A protect code of 0 protects no block. A code n from 1 to 8 protects 2^(n-1) blocks. A code of 9 to 15 protects all 256 blocks.
- R2: With direction bit 0 the protected run ends at block 255 (it grows down). With direction bit 1 it starts at block 0 (it grows up). A `sr_wr_stb` loads both the code and the direction bit. Reset clears the direction bit to 0 and leaves the code unchanged.
- R3: `mode_sel_stb` switches the block to individual mode for good. No later command and no reset returns it to group mode.
- R4: The region index is computed as follows. Block 0 gives regions 0..15, selected by address bits 15..12. Blocks 1..254 give regions 16..269 (block + 15). Block 255 gives regions 270..285, selected by address bits 15..12.
- R5: In individual mode a location is protected when the volatile bit or the nonvolatile bit of its region is set, and allowed only when both are clear.
- R6: Reset sets every volatile lock bit, clears the freeze, and drives `prot_vld`, `rd_vld` and `nv_err` to 0. The nonvolatile bits start cleared at power-up and keep their value through a reset.
- R7: `gang_lock_stb` sets every volatile lock bit. `gang_unlock_stb` clears every volatile lock bit. If both strobes come in the same cycle, lock wins. Both strobes take priority over a single-bit write.
- R8: `vlk_wr_stb` writes `vlk_wr_val` into the volatile bit of the addressed region. `rd_stb` returns, one cycle later with `rd_vld`=1, 8'hFF if the selected bit is set and 8'h00 if it is clear. `rd_sel`=0 selects the volatile bit and `rd_sel`=1 selects the nonvolatile bit.
- R9: `nv_prog_stb` sets the nonvolatile bit of the addressed region. `nv_erase_stb` clears all nonvolatile bits (erase wins). Either change is visible from the cycle after the strobe.
- R10: After `nv_freeze_stb`, program and erase requests to the nonvolatile bits are ignored until the next reset. Each such request raises `nv_err` for exactly the cycle after its strobe.
- R11: `prot` and `prot_vld` are registered one cycle after `chk_stb`. They reflect the lock state as it stood at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_addr | input | 24 | Byte address shared by all addressed commands |
| sr_wr_stb | input | 1 | Load group protect code and direction bit |
| sr_code | input | 4 | Group protect code |
| sr_tb | input | 1 | Group direction: 0 from top, 1 from bottom |
| mode_sel_stb | input | 1 | One-way switch to individual mode |
| chk_stb | input | 1 | Evaluate protection of cmd_addr |
| gang_lock_stb | input | 1 | Set all volatile lock bits |
| gang_unlock_stb | input | 1 | Clear all volatile lock bits |
| vlk_wr_stb | input | 1 | Write one volatile lock bit |
| vlk_wr_val | input | 1 | Value for the volatile bit write |
| nv_prog_stb | input | 1 | Set the addressed nonvolatile lock bit |
| nv_erase_stb | input | 1 | Clear all nonvolatile lock bits |
| nv_freeze_stb | input | 1 | Freeze nonvolatile bits until reset |
| rd_stb | input | 1 | Read back a lock bit of the addressed region |
| rd_sel | input | 1 | 0 volatile bit, 1 nonvolatile bit |
| prot | output | 1 | Protected verdict for the last check |
| prot_vld | output | 1 | prot is valid this cycle |
| rd_data | output | 8 | 8'hFF locked, 8'h00 unlocked |
| rd_vld | output | 1 | rd_data is valid this cycle |
| nv_err | output | 1 | Nonvolatile request rejected by freeze |

## Verification
The bench builds the unit with its default parameters: a 24-bit address, 4KB sectors, 64KB blocks and a 4-bit code. This puts all 286 regions within reach, including both sector strips and the seam blocks 1 and 254. Random addresses are biased toward blocks 0, 1, 254 and 255, so the boundary of the region map is hit often. Every code from 0 to 15 is swept in both directions at the edges of the protected runs. Random sessions mix resets into the stream, which shows volatile bits returning to locked while nonvolatile bits, the freeze release and the sticky mode behave as required.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  // Lock-bit read selection
  typedef enum logic {
    LSEL_VOL = 1'b0,
    LSEL_NV  = 1'b1
  } lock_sel_e;

  localparam logic [7:0] RD_LOCKED   = 8'hFF;
  localparam logic [7:0] RD_UNLOCKED = 8'h00;
endpackage

// File: rtl/fwp_region_map.sv
// Address to region index: fine sectors at both ends, coarse blocks between.
module fwp_region_map #(
  parameter int ADDR_W   = 24,
  parameter int BLK_BITS = 16,
  parameter int SEC_BITS = 12,
  localparam int BLK_W   = ADDR_W - BLK_BITS,
  localparam int SUB_W   = BLK_BITS - SEC_BITS,
  localparam int NBLK    = 1 << BLK_W,
  localparam int EDGE    = 1 << SUB_W,
  localparam int NREG    = 2 * EDGE + NBLK - 2,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic [ADDR_W-1:SEC_BITS] addr_hi,
  output logic [BLK_W-1:0]         blk,
  output logic [IDX_W-1:0]         idx
);
  logic [SUB_W-1:0] sub;

  assign blk = addr_hi[ADDR_W-1:BLK_BITS];
  assign sub = addr_hi[BLK_BITS-1:SEC_BITS];

  always_comb begin
    if (blk == '0)
      idx = IDX_W'(sub);
    else if (blk == BLK_W'(NBLK - 1))
      idx = IDX_W'(EDGE + NBLK - 2) + IDX_W'(sub);
    else
      idx = IDX_W'(blk) + IDX_W'(EDGE - 1);
  end
endmodule

// File: rtl/fwp_group_decode.sv
// Group protection: power-of-two run of blocks from one end of the array.
module fwp_group_decode #(
  parameter int BLK_W  = 8,
  parameter int CODE_W = 4,
  localparam int CNT_W = BLK_W + 1,
  localparam int NBLK  = 1 << BLK_W
) (
  input  logic [CODE_W-1:0] code,
  input  logic              from_bottom,
  input  logic [BLK_W-1:0]  blk,
  output logic              prot
);
  localparam logic [CODE_W-1:0] FULL_CODE = CODE_W'(BLK_W);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] blk_x;
  logic             all_on;

  assign blk_x = {1'b0, blk};

  always_comb begin
    cnt    = '0;
    all_on = 1'b0;
    if (code > FULL_CODE)
      all_on = 1'b1;
    else if (code != '0)
      cnt = CNT_W'(1) << (code - CODE_W'(1));
  end

  always_comb begin
    if (all_on)
      prot = 1'b1;
    else if (from_bottom)
      prot = blk_x < cnt;
    else
      prot = blk_x >= (CNT_W'(NBLK) - cnt);
  end
endmodule

// File: rtl/fwp_lock_array.sv
// Per-region volatile and nonvolatile lock bits with freeze control.
module fwp_lock_array #(
  parameter int NREG  = 286,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             gang_lock,
  input  logic             gang_unlock,
  input  logic             vwr,
  input  logic             vwr_val,
  input  logic             nv_prog,
  input  logic             nv_erase,
  input  logic             freeze,
  output logic             vol_bit,
  output logic             nv_bit,
  output logic             frozen
);
  logic [NREG-1:0] vol_q;
  logic [NREG-1:0] nv_q = '0;   // power-up clear, no reset: survives rst
  logic            frz_q;

  // One flop per region; gang commands override the single-bit write.
  for (genvar g = 0; g < NREG; g++) begin : g_vol
    always_ff @(posedge clk) begin
      if (rst)
        vol_q[g] <= 1'b1;
      else if (gang_lock)
        vol_q[g] <= 1'b1;
      else if (gang_unlock)
        vol_q[g] <= 1'b0;
      else if (vwr && idx == IDX_W'(g))
        vol_q[g] <= vwr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      frz_q <= 1'b0;
    else if (freeze)
      frz_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst && !frz_q) begin
      if (nv_erase)
        nv_q <= '0;
      else if (nv_prog)
        nv_q[idx] <= 1'b1;
    end
  end

  assign vol_bit = vol_q[idx];
  assign nv_bit  = nv_q[idx];
  assign frozen  = frz_q;
endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit #(
  parameter int ADDR_W   = 24,
  parameter int BLK_BITS = 16,
  parameter int SEC_BITS = 12,
  parameter int CODE_W   = 4,
  localparam int BLK_W   = ADDR_W - BLK_BITS,
  localparam int EDGE    = 1 << (BLK_BITS - SEC_BITS),
  localparam int NREG    = 2 * EDGE + (1 << BLK_W) - 2,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              sr_wr_stb,
  input  logic [CODE_W-1:0] sr_code,
  input  logic              sr_tb,
  input  logic              mode_sel_stb,
  input  logic              chk_stb,
  input  logic              gang_lock_stb,
  input  logic              gang_unlock_stb,
  input  logic              vlk_wr_stb,
  input  logic              vlk_wr_val,
  input  logic              nv_prog_stb,
  input  logic              nv_erase_stb,
  input  logic              nv_freeze_stb,
  input  logic              rd_stb,
  input  logic              rd_sel,
  output logic              prot,
  output logic              prot_vld,
  output logic [7:0]        rd_data,
  output logic              rd_vld,
  output logic              nv_err
);
  import fwp_pkg::*;

  logic [BLK_W-1:0]  blk;
  logic [IDX_W-1:0]  idx;
  logic              grp_prot;
  logic              vol_bit;
  logic              nv_bit;
  logic              frozen;
  logic              prot_d;
  logic              sel_bit;

  // Nonvolatile-like state: power-up value only, untouched by rst
  logic              ind_mode_q = 1'b0;
  logic [CODE_W-1:0] grp_code_q = '0;
  logic              tb_q;

  fwp_region_map #(
    .ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .SEC_BITS(SEC_BITS)
  ) u_map (
    .addr_hi(cmd_addr[ADDR_W-1:SEC_BITS]),
    .blk    (blk),
    .idx    (idx)
  );

  fwp_group_decode #(
    .BLK_W(BLK_W), .CODE_W(CODE_W)
  ) u_grp (
    .code       (grp_code_q),
    .from_bottom(tb_q),
    .blk        (blk),
    .prot       (grp_prot)
  );

  fwp_lock_array #(
    .NREG(NREG)
  ) u_locks (
    .clk        (clk),
    .rst        (rst),
    .idx        (idx),
    .gang_lock  (gang_lock_stb),
    .gang_unlock(gang_unlock_stb),
    .vwr        (vlk_wr_stb),
    .vwr_val    (vlk_wr_val),
    .nv_prog    (nv_prog_stb),
    .nv_erase   (nv_erase_stb),
    .freeze     (nv_freeze_stb),
    .vol_bit    (vol_bit),
    .nv_bit     (nv_bit),
    .frozen     (frozen)
  );

  always_ff @(posedge clk) begin
    if (!rst && mode_sel_stb)
      ind_mode_q <= 1'b1;
    if (!rst && sr_wr_stb)
      grp_code_q <= sr_code;
  end

  always_ff @(posedge clk) begin
    if (rst)
      tb_q <= 1'b0;
    else if (sr_wr_stb)
      tb_q <= sr_tb;
  end

  assign prot_d  = ind_mode_q ? (vol_bit | nv_bit) : grp_prot;
  assign sel_bit = (lock_sel_e'(rd_sel) == LSEL_NV) ? nv_bit : vol_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prot     <= 1'b0;
      prot_vld <= 1'b0;
      rd_data  <= RD_UNLOCKED;
      rd_vld   <= 1'b0;
      nv_err   <= 1'b0;
    end else begin
      prot_vld <= chk_stb;
      if (chk_stb)
        prot <= prot_d;
      rd_vld <= rd_stb;
      if (rd_stb)
        rd_data <= sel_bit ? RD_LOCKED : RD_UNLOCKED;
      nv_err <= frozen & (nv_prog_stb | nv_erase_stb);
    end
  end
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              chk_stb,
  input logic              prot,
  input logic              prot_vld,
  input logic              rd_vld,
  input logic [7:0]        rd_data,
  input logic              nv_err,
  input logic              nv_prog_stb,
  input logic              nv_erase_stb,
  input logic              frozen,
  input logic              ind_mode,
  input logic [CODE_W-1:0] grp_code
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    ind_mode |=> ind_mode) else $error("mode left individual"); // R3

  AST_GROUP_NONE: assert property (@(posedge clk) disable iff (rst)
    (prot_vld && $past(chk_stb) && !$past(ind_mode) && $past(grp_code) == '0) |-> !prot)
    else $error("code 0 protected"); // R1

  AST_CHK_LATENCY: assert property (@(posedge clk) disable iff (rst)
    chk_stb |=> prot_vld) else $error("verdict missing"); // R11

  AST_RD_CODE: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> (rd_data == 8'hFF || rd_data == 8'h00)) else $error("bad read code"); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    nv_err |-> $past(frozen && (nv_prog_stb || nv_erase_stb)))
    else $error("spurious nv error"); // R10

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_FREEZE_CLEAR: assert (!frozen) else $error("freeze survived reset"); // R6
    end
  end
endmodule

bind flash_wp_unit fwp_checker #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .chk_stb     (chk_stb),
  .prot        (prot),
  .prot_vld    (prot_vld),
  .rd_vld      (rd_vld),
  .rd_data     (rd_data),
  .nv_err      (nv_err),
  .nv_prog_stb (nv_prog_stb),
  .nv_erase_stb(nv_erase_stb),
  .frozen      (frozen),
  .ind_mode    (ind_mode_q),
  .grp_code    (grp_code_q)
);

// File: tb/flash_wp_unit_test.sv
`timescale 1ns/1ps
module flash_wp_unit_test;
  localparam int NREG = 286;
  localparam int OP_VWR = 0, OP_GL = 1, OP_GU = 2, OP_NVP = 3, OP_NVE = 4,
                 OP_FRZ = 5, OP_SR = 6, OP_MODE = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] cmd_addr = '0;
  logic sr_wr_stb = 0, sr_tb = 0, mode_sel_stb = 0, chk_stb = 0;
  logic [3:0] sr_code = '0;
  logic gang_lock_stb = 0, gang_unlock_stb = 0, vlk_wr_stb = 0, vlk_wr_val = 0;
  logic nv_prog_stb = 0, nv_erase_stb = 0, nv_freeze_stb = 0, rd_stb = 0, rd_sel = 0;
  logic prot, prot_vld, rd_vld, nv_err;
  logic [7:0] rd_data;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // reference state
  bit m_vol [NREG];
  bit m_nv  [NREG];
  bit m_mode = 0, m_tb = 0, m_frz = 0;
  int m_code = 0;

  always #2.5 clk = ~clk;

  flash_wp_unit uut (.*);

  function automatic int exp_idx(logic [23:0] a);
    int b = int'(a[23:16]);
    int s = int'(a[15:12]);
    if (b == 0) return s;
    if (b == 255) return 270 + s;
    return b + 15;
  endfunction

  function automatic bit exp_grp(int code, bit tb, int b);
    int cnt;
    if (code == 0) return 0;
    if (code >= 9) return 1;
    cnt = 1 << (code - 1);
    return tb ? (b < cnt) : (b >= 256 - cnt);
  endfunction

  function automatic bit exp_prot(logic [23:0] a);
    int i = exp_idx(a);
    if (m_mode) return m_vol[i] | m_nv[i];
    return exp_grp(m_code, m_tb, int'(a[23:16]));
  endfunction

  task automatic check(int act, int exp, string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    foreach (m_vol[i]) m_vol[i] = 1;
    m_tb = 0; m_frz = 0;
    check(prot_vld, 0, "R6"); check(rd_vld, 0, "R6"); check(nv_err, 0, "R6");
  endtask

  task automatic op_chk(logic [23:0] a, string req);
    @(negedge clk); cmd_addr = a; chk_stb = 1;
    @(negedge clk); chk_stb = 0;
    check(prot_vld, 1, "R11");
    check(prot, exp_prot(a), req);
    @(negedge clk);
    check(prot_vld, 0, "R11");
  endtask

  task automatic op_rd(logic [23:0] a, bit sel);
    int i = exp_idx(a);
    bit b = sel ? m_nv[i] : m_vol[i];
    @(negedge clk); cmd_addr = a; rd_sel = sel; rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    check(rd_vld, 1, "R8");
    check(rd_data, b ? 8'hFF : 8'h00, sel ? "R9" : "R8");
  endtask

  task automatic op_cmd(int kind, logic [23:0] a, bit v, int code);
    int i = exp_idx(a);
    bit e = m_frz && (kind == OP_NVP || kind == OP_NVE);
    @(negedge clk);
    cmd_addr = a;
    case (kind)
      OP_VWR:  begin vlk_wr_stb = 1; vlk_wr_val = v; end
      OP_GL:   gang_lock_stb = 1;
      OP_GU:   gang_unlock_stb = 1;
      OP_NVP:  nv_prog_stb = 1;
      OP_NVE:  nv_erase_stb = 1;
      OP_FRZ:  nv_freeze_stb = 1;
      OP_SR:   begin sr_wr_stb = 1; sr_code = 4'(code); sr_tb = v; end
      default: mode_sel_stb = 1;
    endcase
    @(negedge clk);
    {vlk_wr_stb, gang_lock_stb, gang_unlock_stb, nv_prog_stb, nv_erase_stb,
     nv_freeze_stb, sr_wr_stb, mode_sel_stb} = '0;
    case (kind)
      OP_VWR:  m_vol[i] = v;
      OP_GL:   foreach (m_vol[k]) m_vol[k] = 1;
      OP_GU:   foreach (m_vol[k]) m_vol[k] = 0;
      OP_NVP:  if (!m_frz) m_nv[i] = 1;
      OP_NVE:  if (!m_frz) foreach (m_nv[k]) m_nv[k] = 0;
      OP_FRZ:  m_frz = 1;
      OP_SR:   begin m_code = code; m_tb = v; end
      default: m_mode = 1;
    endcase
    check(nv_err, e, "R10");
  endtask

  function automatic logic [23:0] rnd_addr();
    int b;
    case ($urandom % 6)
      0: b = 0; 1: b = 255; 2: b = 1; 3: b = 254;
      default: b = $urandom % 256;
    endcase
    return {8'(b), 16'($urandom)};
  endfunction

  task automatic rnd_ops(int n, bit allow_mode);
    for (int k = 0; k < n; k++) begin
      logic [23:0] a = rnd_addr();
      int r = $urandom % 40;
      if (r < 10)       op_chk(a, m_mode ? "R5" : "R1");
      else if (r < 15)  op_rd(a, 1'($urandom));
      else if (r < 21)  op_cmd(OP_VWR, a, 1'($urandom), 0);
      else if (r < 22)  op_cmd(OP_GL, a, 0, 0);
      else if (r < 24)  op_cmd(OP_GU, a, 0, 0);
      else if (r < 28)  op_cmd(OP_NVP, a, 0, 0);
      else if (r < 29)  op_cmd(OP_NVE, a, 0, 0);
      else if (r < 30)  op_cmd(OP_FRZ, a, 0, 0);
      else if (r < 34)  op_cmd(OP_SR, a, 1'($urandom), int'($urandom % 16));
      else if (r < 35)  do_reset();
      else if (r < 36 && allow_mode) op_cmd(OP_MODE, a, 0, 0);
      else              op_chk(a, m_mode ? "R5" : "R1");
    end
  endtask

  initial begin
    int blks [10] = '{0, 1, 3, 127, 128, 191, 192, 252, 254, 255};
    void'($urandom(32'h5EED));
    foreach (m_nv[i]) m_nv[i] = 0;
    do_reset();
    op_chk(24'hFFFFFF, "R1");
    op_rd(24'h000000, 0);                       // R6 volatile locked after reset
    // R1 / R2 sweep of every code in both directions
    for (int c = 0; c < 16; c++) begin
      for (int t = 0; t < 2; t++) begin
        op_cmd(OP_SR, 0, 1'(t), c);
        foreach (blks[j]) op_chk({8'(blks[j]), 16'h8000}, t ? "R2" : "R1");
      end
    end
    // R2 direction bit cleared by reset, code kept
    op_cmd(OP_SR, 0, 1, 1);
    do_reset();
    op_chk(24'hFF0000, "R2");
    op_chk(24'h000000, "R2");
    rnd_ops(800, 0);
    // individual mode
    op_cmd(OP_MODE, 0, 0, 0);
    op_cmd(OP_GL, 0, 0, 0);
    op_chk(24'h345678, "R5");
    op_cmd(OP_GU, 0, 0, 0);
    op_chk(24'h345678, "R7");
    // R4 region boundaries
    op_cmd(OP_VWR, 24'h003000, 1, 0);
    op_chk(24'h003FFF, "R4"); op_chk(24'h004000, "R4"); op_chk(24'h002FFF, "R4");
    op_cmd(OP_VWR, 24'h071234, 1, 0);
    op_chk(24'h07FFFF, "R4"); op_chk(24'h080000, "R4");
    op_cmd(OP_VWR, 24'hFFF000, 1, 0);
    op_chk(24'hFFFABC, "R4"); op_chk(24'hFFE000, "R4"); op_chk(24'hFE0000, "R4");
    op_cmd(OP_GL, 0, 0, 0);
    op_chk(24'h800000, "R7");
    // R9 nonvolatile program / erase
    op_cmd(OP_GU, 0, 0, 0);
    op_cmd(OP_NVP, 24'h100000, 0, 0);
    op_chk(24'h100000, "R9"); op_rd(24'h100000, 1);
    op_cmd(OP_NVE, 0, 0, 0);
    op_rd(24'h100000, 1); op_chk(24'h100000, "R9");
    // R10 freeze; R3 / R6 across reset
    op_cmd(OP_NVP, 24'h200000, 0, 0);
    op_cmd(OP_FRZ, 0, 0, 0);
    op_cmd(OP_NVP, 24'h300000, 0, 0);
    op_rd(24'h300000, 1);
    op_cmd(OP_NVE, 0, 0, 0);
    op_rd(24'h200000, 1);
    do_reset();
    op_chk(24'h300000, "R3");
    op_rd(24'h200000, 1);                       // R6 nonvolatile kept
    op_cmd(OP_GU, 0, 0, 0);
    op_cmd(OP_NVP, 24'h300000, 0, 0);
    op_chk(24'h300000, "R10");
    rnd_ops(2500, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule